// File: doc/BRIEF.md
# Ultraviolet-Erasable Word Memory Core

A clocked, synthesizable behavioural model of a word-wide, electrically programmable memory that software never sees directly. It is driven entirely through its control pins. A chip-select and an output-select pick between reading, standby and output disable. Three flags tell the core which pins sit at their elevated voltage: the programming supply, the output-select pin and one address pin. Those flags select the programming, page and identifier behaviours. Programming can only turn ones into zeros. A single global-erase input stands in for ultraviolet exposure: it sweeps the whole array back to all ones.

Word programming writes one word per program pulse. Page programming is armed by raising the output-select pin to high voltage while the programming supply is already high. It then collects up to four words in a latch and writes them all to one page on a single program pulse. The page mode stays armed until the supply drops. An identifier read returns a fixed maker code and part code. Every pin is sampled on the clock. Data reaches the registered outputs two cycles after the pins that ask for it.

Top module: `eprom_core`

## Requirements
- R1: Reset and global erase both start a sweep that lasts 2^(ARRAY_AW-2) cycles. During reset, `dout_en` and `dout` are 0. During the sweep `dout_en` stays 0. Afterwards every word reads 0xFFFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=0, the word at `addr` appears on `dout` with `dout_en`=1, two clock edges after the pins are sampled.
- R3: With `vpp_hi`=0 and either `ce_n`=1 or `oe_n`=1, `dout_en` is 0 and `dout` is 0x0000.
- R4: With `vpp_hi`=0, `a9_hv`=1, `ce_n`=0 and `oe_n`=0, `dout` is 0x0007 when `addr[0]`=0 and 0x00A2 when `addr[0]`=1; the other address bits do not matter.
- R5: When page mode is not armed and `vpp_hi`=1, `oe_hv`=0, `oe_n`=1, a transition of `ce_n` to 0 programs exactly one word at `addr` with `din`; neighbouring words are unchanged.
- R6: A program stores old AND new, so a bit at 0 never returns to 1 except by the sweep of R1.
- R7: With `vpp_hi`=1, `oe_hv`=0 and `oe_n`=0, `dout` shows the stored word at `addr` with `dout_en`=1, whatever the level of `ce_n`.
- R8: `vpp_hi`=1 with `oe_hv`=1 arms page mode. While armed, a program pulse (the condition of R5) writes all four latch words to the page `addr[ARRAY_AW-1:2]`, with latch word k going to the address whose two low bits are k; `addr[1:0]` of the pulse is ignored.
- R9: While armed with `oe_hv`=1, `ce_n`=0 loads `din` into latch word `addr[1:0]`. All latch words become 0xFFFF when page mode arms and after every page program, so unloaded words leave their targets unchanged.
- R10: Page mode stays armed until `vpp_hi` is sampled 0. After that, program pulses write single words again.
- R11: A pulse on `erase_all` restarts the sweep of R1 at any time, drops any program still pending, and returns all programmed words to 0xFFFF.
- R12: The array holds 2^ARRAY_AW words (18 gives the full 262,144). Address bits at ARRAY_AW and above are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, starts the erase sweep |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output select, active low |
| vpp_hi | input | 1 | Programming supply at programming level |
| oe_hv | input | 1 | Output-select pin at high voltage |
| a9_hv | input | 1 | Identifier address pin at high voltage |
| erase_all | input | 1 | Global erase request |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data to program or latch |
| dout | output | DATA_W | Registered read data, 0 when not driven |
| dout_en | output | 1 | Output driven |

## Verification
Several properties are checked on every cycle against the pins sampled two cycles earlier. Disabled or standby pins give a quiet output. A busy sweep keeps the output off. Identifier reads carry the right code. A word program touches exactly one bank. A dropped supply leaves page mode disarmed. A freshly armed page latch holds all ones. Only the bench scenarios can show that data actually persists. Those scenarios check that programs AND into old contents and that a page pulse places each latch word in its slot. They also check that unloaded latch words and a disarmed page leave words untouched, and that an erase returns written words to ones.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_MEM  = 2'd1,
    OUT_ID   = 2'd2
  } out_kind_e;

  localparam int PAGE_WORDS = 4;
  localparam int SEL_W      = $clog2(PAGE_WORDS);

  localparam logic [7:0] MAKER_ID8 = 8'h07;
  localparam logic [7:0] PART_ID8  = 8'hA2;

endpackage

// File: rtl/eprom_bank.sv
module eprom_bank #(
  parameter int ROW_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ROW_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read returns the contents before this edge's write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec (
  input  logic                  busy,
  input  logic                  ce_n,
  input  logic                  oe_n,
  input  logic                  vpp_hi,
  input  logic                  oe_hv,
  input  logic                  a9_hv,
  input  logic                  armed,
  output eprom_pkg::out_kind_e  out_kind,
  output logic                  prog_cond,
  output logic                  latch_cond
);
  import eprom_pkg::*;

  always_comb begin
    out_kind = OUT_NONE;
    if (!busy) begin
      if (!vpp_hi) begin
        if (!ce_n && !oe_n) out_kind = a9_hv ? OUT_ID : OUT_MEM;
      end else if (!oe_n && !oe_hv) begin
        out_kind = OUT_MEM;
      end
    end
  end

  assign prog_cond  = vpp_hi && !oe_hv && !ce_n && oe_n;
  assign latch_cond = vpp_hi && oe_hv && !ce_n && armed;

endmodule

// File: rtl/eprom_page_latch.sv
module eprom_page_latch #(
  parameter int DATA_W = 16
) (
  input  logic                                            clk,
  input  logic                                            rst,
  input  logic                                            vpp_hi,
  input  logic                                            oe_hv,
  input  logic                                            load,
  input  logic [eprom_pkg::SEL_W-1:0]                     sel,
  input  logic [DATA_W-1:0]                               din,
  input  logic                                            flush,
  output logic                                            armed,
  output logic [eprom_pkg::PAGE_WORDS-1:0][DATA_W-1:0]    words
);
  import eprom_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || !vpp_hi) armed <= 1'b0;
    else if (oe_hv)     armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !armed || flush) begin
      words <= '1;
    end else if (load) begin
      words[sel] <= din;
    end
  end

  // R10: a supply sampled low always leaves page mode disarmed
  a_r10_disarm: assert property (@(posedge clk) disable iff (rst)
    !$past(vpp_hi) |-> !armed);

  // R9: the latch is blank on the cycle page mode becomes armed
  a_r9_fresh_latch: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> (words == {PAGE_WORDS*DATA_W{1'b1}}));

endmodule

// File: rtl/eprom_core.sv
module eprom_core #(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int ARRAY_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              oe_hv,
  input  logic              a9_hv,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  import eprom_pkg::*;

  localparam int ROW_W = ARRAY_AW - SEL_W;

  // address split
  logic [ROW_W-1:0] row;
  logic [SEL_W-1:0] sel;
  assign row = addr[ARRAY_AW-1:SEL_W];
  assign sel = addr[SEL_W-1:0];

  generate
    if (ARRAY_AW < ADDR_W) begin : g_alias
      logic unused_hi_addr;
      assign unused_hi_addr = ^addr[ADDR_W-1:ARRAY_AW];
    end
  endgenerate

  // erase sweep
  logic             sweep_busy;
  logic [ROW_W-1:0] sweep_cnt;

  always_ff @(posedge clk) begin
    if (rst || erase_all) begin
      sweep_busy <= 1'b1;
      sweep_cnt  <= '0;
    end else if (sweep_busy) begin
      sweep_cnt <= sweep_cnt + 1'b1;
      if (sweep_cnt == {ROW_W{1'b1}}) sweep_busy <= 1'b0;
    end
  end

  // mode decode and page latch
  out_kind_e out_kind;
  logic      prog_cond, latch_cond, page_armed;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] latch_words;

  eprom_mode_dec u_dec (
    .busy       (sweep_busy),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .vpp_hi     (vpp_hi),
    .oe_hv      (oe_hv),
    .a9_hv      (a9_hv),
    .armed      (page_armed),
    .out_kind   (out_kind),
    .prog_cond  (prog_cond),
    .latch_cond (latch_cond)
  );

  logic prog_q, prog_start, page_start;

  always_ff @(posedge clk) begin
    if (rst) prog_q <= 1'b0;
    else     prog_q <= prog_cond;
  end

  assign prog_start = prog_cond && !prog_q && !sweep_busy;
  assign page_start = prog_start && page_armed;

  eprom_page_latch #(.DATA_W(DATA_W)) u_page (
    .clk    (clk),
    .rst    (rst),
    .vpp_hi (vpp_hi),
    .oe_hv  (oe_hv),
    .load   (latch_cond),
    .sel    (sel),
    .din    (din),
    .flush  (page_start),
    .armed  (page_armed),
    .words  (latch_words)
  );

  // program pulse: read at the start edge, write old AND new one edge later
  logic                              wr_pend, wr_page;
  logic [ROW_W-1:0]                  wr_row;
  logic [PAGE_WORDS-1:0]             wr_mask;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] wr_val;

  always_ff @(posedge clk) begin
    if (rst || sweep_busy || erase_all) begin
      wr_pend <= 1'b0;
      wr_page <= 1'b0;
      wr_mask <= '0;
    end else begin
      wr_pend <= prog_start;
      if (prog_start) begin
        wr_row  <= row;
        wr_page <= page_armed;
        if (page_armed) begin
          wr_mask <= '1;
          wr_val  <= latch_words;
        end else begin
          wr_mask <= PAGE_WORDS'(1) << sel;
          for (int k = 0; k < PAGE_WORDS; k++) wr_val[k] <= din;
        end
      end
    end
  end

  // four banks, one per word of a page
  logic [PAGE_WORDS-1:0]             bank_we;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] bank_rd;
  logic [ROW_W-1:0]                  bank_waddr;

  assign bank_waddr = sweep_busy ? sweep_cnt : wr_row;

  generate
    for (genvar b = 0; b < PAGE_WORDS; b++) begin : g_bank
      logic [DATA_W-1:0] wdata;
      assign bank_we[b] = sweep_busy || (wr_pend && wr_mask[b]);
      assign wdata      = sweep_busy ? {DATA_W{1'b1}} : (bank_rd[b] & wr_val[b]);

      eprom_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .we    (bank_we[b]),
        .waddr (bank_waddr),
        .wdata (wdata),
        .raddr (row),
        .rdata (bank_rd[b])
      );
    end
  endgenerate

  // output pipeline: stage one aligns with the bank read
  out_kind_e        s1_kind;
  logic [SEL_W-1:0] s1_sel;
  logic             s1_part;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_kind <= OUT_NONE;
      s1_sel  <= '0;
      s1_part <= 1'b0;
    end else begin
      s1_kind <= out_kind;
      s1_sel  <= sel;
      s1_part <= addr[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= (s1_kind != OUT_NONE);
      case (s1_kind)
        OUT_MEM: dout <= bank_rd[s1_sel];
        OUT_ID:  dout <= s1_part ? DATA_W'(PART_ID8) : DATA_W'(MAKER_ID8);
        default: dout <= '0;
      endcase
    end
  end

  // R3: deselected or disabled read pins give a quiet output
  a_r3_quiet_out: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(vpp_hi, 2) &&
     ($past(ce_n, 2) || $past(oe_n, 2))) |-> (!dout_en && dout == '0));

  // R1: no output while the erase sweep runs
  a_r1_sweep_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && $past(sweep_busy, 2)) |-> !dout_en);

  // R4: identifier read returns the code chosen by the lowest address bit
  a_r4_id_code: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(sweep_busy, 2) &&
     !$past(vpp_hi, 2) && $past(a9_hv, 2) && !$past(ce_n, 2) && !$past(oe_n, 2))
    |-> (dout_en && dout == ($past(addr[0], 2) ? DATA_W'(PART_ID8) : DATA_W'(MAKER_ID8))));

  // R5: a word program writes into exactly one bank
  a_r5_one_bank: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && !wr_page && !sweep_busy) |-> ($countones(bank_we) == 1));

endmodule

// File: tb/sim_eprom_core.sv
`timescale 1ns/100ps
module sim_eprom_core;

  localparam int AW   = 18;
  localparam int DW   = 16;
  localparam int ARW  = 10;
  localparam int ROWS = 1 << (ARW - 2);

  localparam logic [3:0] OP_PROG = 4'd1, OP_READ = 4'd2, OP_ID = 4'd3,
                         OP_OFF_OE = 4'd4, OP_VERIFY = 4'd5, OP_OFF_CE = 4'd6;
  localparam int NVEC = 17;

  // {op, address, data, expected}
  localparam logic [53:0] VEC [NVEC] = '{
    {OP_READ,   18'h00005, 16'h0000, 16'hFFFF},
    {OP_PROG,   18'h00005, 16'h1234, 16'h0000},
    {OP_READ,   18'h00005, 16'h0000, 16'h1234},
    {OP_PROG,   18'h00005, 16'hFF0F, 16'h0000},
    {OP_READ,   18'h00005, 16'h0000, 16'h1204},
    {OP_PROG,   18'h00005, 16'hFFFF, 16'h0000},
    {OP_READ,   18'h00005, 16'h0000, 16'h1204},
    {OP_ID,     18'h00000, 16'h0000, 16'h0007},
    {OP_ID,     18'h00001, 16'h0000, 16'h00A2},
    {OP_OFF_OE, 18'h00005, 16'h0000, 16'h0000},
    {OP_PROG,   18'h00006, 16'hA5A5, 16'h0000},
    {OP_READ,   18'h00006, 16'h0000, 16'hA5A5},
    {OP_READ,   18'h00004, 16'h0000, 16'hFFFF},
    {OP_VERIFY, 18'h00006, 16'h0000, 16'hA5A5},
    {OP_READ,   18'h00405, 16'h0000, 16'h1204},
    {OP_OFF_CE, 18'h00005, 16'h0000, 16'h0000},
    {OP_VERIFY, 18'h00005, 16'h0000, 16'h1204}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, oe_hv = 1'b0, a9_hv = 1'b0;
  logic erase_all = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  eprom_core #(.ADDR_W(AW), .DATA_W(DW), .ARRAY_AW(ARW)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .oe_hv(oe_hv), .a9_hv(a9_hv), .erase_all(erase_all), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [16:0] exp);
    n_chk++;
    if ({dout_en, dout} !== exp) begin
      n_err++;
      $display("FAIL %s: actual en=%0b data=%h expected en=%0b data=%h",
               tag, dout_en, dout, exp[16], exp[15:0]);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic id, input string tag,
                         input logic [16:0] exp);
    vpp_hi = 1'b0; oe_hv = 1'b0; a9_hv = id; addr = a; ce_n = 1'b0; oe_n = 1'b0;
    idle(3);
    chk(tag, exp);
    ce_n = 1'b1; oe_n = 1'b1; a9_hv = 1'b0;
    idle(1);
  endtask

  task automatic do_verify(input logic [AW-1:0] a, input string tag, input logic [15:0] exp);
    vpp_hi = 1'b1; oe_hv = 1'b0; ce_n = 1'b1; oe_n = 1'b0; addr = a;
    idle(3);
    chk(tag, {1'b1, exp});
    oe_n = 1'b1;
    idle(1);
  endtask

  task automatic pulse(input logic [AW-1:0] a);
    oe_hv = 1'b0; oe_n = 1'b1; ce_n = 1'b1; addr = a;
    idle(1);
    ce_n = 1'b0;
    idle(2);
    ce_n = 1'b1;
    idle(2);
  endtask

  task automatic do_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
    vpp_hi = 1'b1; din = d;
    pulse(a);
  endtask

  task automatic do_latch(input logic [AW-1:0] a, input logic [DW-1:0] d);
    vpp_hi = 1'b1; oe_hv = 1'b1; oe_n = 1'b1; ce_n = 1'b1; addr = a; din = d;
    idle(1);
    ce_n = 1'b0;
    idle(1);
    ce_n = 1'b1;
    idle(1);
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0:          return "R1 blank word";
      2, 11:      return "R5 word program";
      4, 6:       return "R6 clear only";
      7, 8:       return "R4 identifier";
      9, 15:      return "R3 output off";
      12:         return "R5 neighbour kept";
      13, 16:     return "R7 verify";
      14:         return "R12 alias";
      default:    return "R2 read";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // reset state, with read pins active
    ce_n = 1'b0; oe_n = 1'b0;
    idle(3);
    chk("R1 reset state", 17'h0);
    rst = 1'b0;
    idle(4);
    chk("R1 sweep keeps output off", 17'h0);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(ROWS + 10);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [3:0]    op;
      logic [AW-1:0] va;
      logic [DW-1:0] vd, ve;
      {op, va, vd, ve} = VEC[i];
      case (op)
        OP_PROG:   begin do_prog(va, vd); vpp_hi = 1'b0; idle(1); end
        OP_READ:   do_read(va, 1'b0, vec_tag(i), {1'b1, ve});
        OP_ID:     do_read(va, 1'b1, vec_tag(i), {1'b1, ve});
        OP_VERIFY: begin do_verify(va, vec_tag(i), ve); vpp_hi = 1'b0; idle(1); end
        OP_OFF_OE, OP_OFF_CE: begin
          vpp_hi = 1'b0; addr = va;
          ce_n = (op == OP_OFF_CE); oe_n = (op == OP_OFF_OE);
          idle(3);
          chk(vec_tag(i), 17'h0);
          ce_n = 1'b1; oe_n = 1'b1;
          idle(1);
        end
        default: idle(1);
      endcase
    end

    // page programming
    vpp_hi = 1'b0; idle(2);
    do_latch(18'h00020, 16'h1111);
    do_latch(18'h00022, 16'h3333);
    pulse(18'h00021);
    do_verify(18'h00020, "R8 page slot 0", 16'h1111);
    do_verify(18'h00021, "R9 unloaded slot 1", 16'hFFFF);
    do_verify(18'h00022, "R8 page slot 2", 16'h3333);
    do_verify(18'h00023, "R9 unloaded slot 3", 16'hFFFF);
    do_latch(18'h00031, 16'h2222);
    pulse(18'h00030);
    do_verify(18'h00030, "R9 latch flushed after page", 16'hFFFF);
    do_verify(18'h00031, "R8 still armed second page", 16'h2222);

    // disarm, then single-word programming again
    vpp_hi = 1'b0; idle(2);
    do_prog(18'h00041, 16'h0F0F);
    vpp_hi = 1'b0; idle(1);
    do_read(18'h00041, 1'b0, "R10 word after disarm", {1'b1, 16'h0F0F});
    do_read(18'h00040, 1'b0, "R10 page neighbour kept", {1'b1, 16'hFFFF});

    // global erase
    erase_all = 1'b1; idle(1); erase_all = 1'b0;
    do_read(18'h00005, 1'b0, "R11 output off while erasing", 17'h0);
    idle(ROWS + 10);
    do_read(18'h00005, 1'b0, "R11 erased word", {1'b1, 16'hFFFF});
    do_read(18'h00020, 1'b0, "R11 erased page", {1'b1, 16'hFFFF});
    do_read(18'h00041, 1'b0, "R11 erased second word", {1'b1, 16'hFFFF});

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule